// File: doc/BRIEF.md
# Inclusive L2 Coherence Filter

This block sits on the L2 side of a private two-level cache hierarchy, in which the L1 is write-back and the L2 includes everything the L1 holds. For every L2 line it keeps a coherence state and two tracking bits. The first bit records that L1 also holds the line. The second records that the L1 copy is dirty. With these bits, bus snoops reach the L1 only when the L1 can actually hold the block, and a flush is requested only when the L1 has the newest data.

The filter applies response fills to its state table. When the L2 controller evicts a block, the filter sends the L1 one back-invalidation per L1 sub-block covered by that L2 block. The command is a flush when the L1 copy is dirty and an invalidate otherwise. Each command waits for an acknowledgement before the next one is sent. The filter also handles the L1's own eviction notices and write-backs. A combinational query port lets the surrounding L2 controller read any line's record.

Top module: `incl_filter`

## Requirements
- R1: After reset every line reads state I (code 0) with both tracking bits clear. busy, fwdValid, snoopHit, snoopDirty, l1CmdValid and evictDone are 0.
- R2: A read fill (fillWrite=0) sets the line to S (code 1) when fillShared=1, or to E (code 2) otherwise. It sets the in-L1 bit and clears the dirty-in-L1 bit.
- R3: A write fill (fillWrite=1) sets the line to M (code 3) and sets both the in-L1 and the dirty-in-L1 bits.
- R4: In the cycle after an accepted snoop, snoopHit is 1 when the line was not I, and snoopDirty is 1 when the line was M. A line that is dirty in L1 counts as M.
- R5: In the cycle after an accepted snoop, fwdValid is 1 exactly when the line's in-L1 bit was set. fwdFlush equals the dirty-in-L1 bit, and fwdIdx and fwdExcl echo the snoop.
- R6: A shared snoop (snoopExcl=0) moves E or M to S, keeps the in-L1 bit and clears the dirty-in-L1 bit. An exclusive snoop moves the line to I and clears both bits.
- R7: Evicting a line whose in-L1 bit is set raises l1CmdValid with l1CmdSub = 0, 1, ... up to SUB_COUNT-1, in that order. Each command is held until l1Ack. l1CmdOp is 1 (flush) when the line was dirty in L1 and 0 (invalidate) otherwise.
- R8: evictDone pulses for one cycle. It comes in the cycle after the last acknowledged command, or in the cycle after acceptance when the line is absent from L1. evictWb is then 1 exactly when the line was M, and the line reads I with both bits clear.
- R9: An L1 eviction notice clears both tracking bits and leaves the L2 state unchanged.
- R10: An L1 write-back clears the dirty-in-L1 bit, leaving the line in M with the in-L1 bit set.
- R11: While busy (an eviction waiting on L1 acknowledgements), fill, snoop, eviction and L1 notice inputs are ignored.
- R12: When several requests arrive in one cycle, only the highest is taken, in the order snoop, eviction, fill, L1 write-back, L1 eviction notice. The others are dropped.
- R13: A set dirty-in-L1 bit always comes with a set in-L1 bit and state M. A set in-L1 bit never comes with state I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | Bus snoop request for one line |
| snoopExcl | input | 1 | 1: exclusive (invalidating) snoop, 0: shared read snoop |
| snoopIdx | input | IDX_W | Line index of the snoop |
| fillValid | input | 1 | Response fill of a line |
| fillWrite | input | 1 | 1: write response, 0: read response |
| fillShared | input | 1 | Read response saw other sharers |
| fillIdx | input | IDX_W | Line index of the fill |
| evictValid | input | 1 | L2 eviction of a line |
| evictIdx | input | IDX_W | Line index of the eviction |
| l1WbValid | input | 1 | L1 wrote back a dirty block |
| l1WbIdx | input | IDX_W | Line index of the write-back |
| l1EvictValid | input | 1 | L1 dropped a block |
| l1EvictIdx | input | IDX_W | Line index of the L1 drop |
| l1Ack | input | 1 | L1 accepted the current back-invalidation |
| qIdx | input | IDX_W | Query line index |
| busy | output | 1 | Eviction in progress; requests ignored |
| snoopHit | output | 1 | Snooped line was valid |
| snoopDirty | output | 1 | Snooped line answers as modified |
| fwdValid | output | 1 | Snoop forwarded to L1 |
| fwdExcl | output | 1 | Forwarded snoop is exclusive |
| fwdFlush | output | 1 | Forwarded snoop must fetch data from L1 |
| fwdIdx | output | IDX_W | Line index of the forwarded snoop |
| l1CmdValid | output | 1 | Back-invalidation command to L1 |
| l1CmdOp | output | 1 | 1: flush, 0: invalidate |
| l1CmdSub | output | SUB_W | L1 sub-block within the L2 block |
| l1CmdIdx | output | IDX_W | L2 line index of the command |
| evictDone | output | 1 | Eviction finished (one-cycle pulse) |
| evictWb | output | 1 | Evicted line was M and needs a write-back |
| qState | output | 2 | Queried line state (I=0, S=1, E=2, M=3) |
| qInL1 | output | 1 | Queried line in-L1 bit |
| qDirtyL1 | output | 1 | Queried line dirty-in-L1 bit |

## Verification
The hardest situation to reach is an eviction that is part-way through its back-invalidations while other requests arrive. The bench holds l1Ack low for different numbers of cycles per sub-block. During that wait it injects a fill to a neighbouring line, and it then reads the neighbour through the query port to prove the fill was dropped. The main sweep visits every line in every reachable tracking state: absent, read-shared, read-exclusive, written, written then written back, and so on. For each of these it applies every operation, so both command opcodes and both completion paths of the eviction occur on every index.

// File: rtl/incl_filter_pkg.sv
package incl_filter_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  typedef struct packed {
    lineState_t st;
    logic       inL1;
    logic       dirtyL1;
  } lineRec_t;

  typedef struct packed {
    logic     wrEn;
    lineRec_t rec;
  } tblStrobe_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_SNOOP = 3'd1,
    OP_EVICT = 3'd2,
    OP_FILL  = 3'd3,
    OP_WB    = 3'd4,
    OP_L1EV  = 3'd5
  } opSel_t;

  typedef enum logic {
    FSM_IDLE = 1'b0,
    FSM_CMD  = 1'b1
  } fsm_t;

endpackage

// File: rtl/incl_line_table.sv
module incl_line_table
  import incl_filter_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tblStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output lineRec_t         rdRec,
  input  logic [IDX_W-1:0] qIdx,
  output lineRec_t         qRec
);

  lineRec_t recs [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        recs[g] <= '{st: LINE_I, inL1: 1'b0, dirtyL1: 1'b0};
      end else if (strobe.wrEn && (wrIdx == IDX_W'(g))) begin
        recs[g] <= strobe.rec;
      end
    end
  end

  assign rdRec = recs[rdIdx];
  assign qRec  = recs[qIdx];

endmodule

// File: rtl/incl_ctrl.sv
module incl_ctrl
  import incl_filter_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int SUB_COUNT = 2,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SUB_W = (SUB_COUNT > 1) ? $clog2(SUB_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             snoopValid,
  input  logic             snoopExcl,
  input  logic [IDX_W-1:0] snoopIdx,
  input  logic             fillValid,
  input  logic             fillWrite,
  input  logic             fillShared,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictIdx,
  input  logic             l1WbValid,
  input  logic [IDX_W-1:0] l1WbIdx,
  input  logic             l1EvictValid,
  input  logic [IDX_W-1:0] l1EvictIdx,
  input  logic             l1Ack,
  input  lineRec_t         rdRec,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] wrIdx,
  output tblStrobe_t       strobe,
  output logic             busy,
  output logic             snoopHit,
  output logic             snoopDirty,
  output logic             fwdValid,
  output logic             fwdExcl,
  output logic             fwdFlush,
  output logic [IDX_W-1:0] fwdIdx,
  output logic             l1CmdValid,
  output logic             l1CmdOp,
  output logic [SUB_W-1:0] l1CmdSub,
  output logic [IDX_W-1:0] l1CmdIdx,
  output logic             evictDone,
  output logic             evictWb
);

  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUB_COUNT - 1);

  fsm_t             fsm;
  logic [SUB_W-1:0] subCnt;
  logic [IDX_W-1:0] evIdxQ;
  logic             evFlushQ;
  logic             evWbQ;
  opSel_t           opSel;
  logic [IDX_W-1:0] opIdx;
  logic             lastAck;

  assign busy    = (fsm == FSM_CMD);
  assign lastAck = busy && l1Ack && (subCnt == LAST_SUB);

  // Request selection: fixed priority, nothing accepted during an eviction.
  always_comb begin
    opSel = OP_NONE;
    opIdx = '0;
    if (!busy) begin
      if (snoopValid) begin
        opSel = OP_SNOOP; opIdx = snoopIdx;
      end else if (evictValid) begin
        opSel = OP_EVICT; opIdx = evictIdx;
      end else if (fillValid) begin
        opSel = OP_FILL; opIdx = fillIdx;
      end else if (l1WbValid) begin
        opSel = OP_WB; opIdx = l1WbIdx;
      end else if (l1EvictValid) begin
        opSel = OP_L1EV; opIdx = l1EvictIdx;
      end
    end
  end

  assign rdIdx = busy ? evIdxQ : opIdx;
  assign wrIdx = busy ? evIdxQ : opIdx;

  // Next record for the selected line.
  always_comb begin
    strobe.wrEn = 1'b0;
    strobe.rec  = rdRec;
    unique case (opSel)
      OP_SNOOP: begin
        strobe.wrEn = 1'b1;
        if (snoopExcl) begin
          strobe.rec = '{st: LINE_I, inL1: 1'b0, dirtyL1: 1'b0};
        end else begin
          strobe.rec.st      = (rdRec.st == LINE_I) ? LINE_I : LINE_S;
          strobe.rec.dirtyL1 = 1'b0;
        end
      end
      OP_EVICT: begin
        if (!rdRec.inL1) begin
          strobe.wrEn = 1'b1;
          strobe.rec  = '{st: LINE_I, inL1: 1'b0, dirtyL1: 1'b0};
        end
      end
      OP_FILL: begin
        strobe.wrEn = 1'b1;
        if (fillWrite) begin
          strobe.rec = '{st: LINE_M, inL1: 1'b1, dirtyL1: 1'b1};
        end else begin
          strobe.rec = '{st: (fillShared ? LINE_S : LINE_E), inL1: 1'b1, dirtyL1: 1'b0};
        end
      end
      OP_WB: begin
        strobe.wrEn        = 1'b1;
        strobe.rec.dirtyL1 = 1'b0;
      end
      OP_L1EV: begin
        strobe.wrEn        = 1'b1;
        strobe.rec.inL1    = 1'b0;
        strobe.rec.dirtyL1 = 1'b0;
      end
      default: ;
    endcase
    if (lastAck) begin
      strobe.wrEn = 1'b1;
      strobe.rec  = '{st: LINE_I, inL1: 1'b0, dirtyL1: 1'b0};
    end
  end

  // Snoop response and upward forwarding.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snoopHit   <= 1'b0;
      snoopDirty <= 1'b0;
      fwdValid   <= 1'b0;
      fwdExcl    <= 1'b0;
      fwdFlush   <= 1'b0;
      fwdIdx     <= '0;
    end else begin
      snoopHit   <= (opSel == OP_SNOOP) && (rdRec.st != LINE_I);
      snoopDirty <= (opSel == OP_SNOOP) && (rdRec.st == LINE_M);
      fwdValid   <= (opSel == OP_SNOOP) && rdRec.inL1;
      fwdFlush   <= (opSel == OP_SNOOP) && rdRec.inL1 && rdRec.dirtyL1;
      if (opSel == OP_SNOOP) begin
        fwdExcl <= snoopExcl;
        fwdIdx  <= snoopIdx;
      end
    end
  end

  // Eviction sequencer: one back-invalidation per L1 sub-block.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm       <= FSM_IDLE;
      subCnt    <= '0;
      evIdxQ    <= '0;
      evFlushQ  <= 1'b0;
      evWbQ     <= 1'b0;
      evictDone <= 1'b0;
      evictWb   <= 1'b0;
    end else begin
      evictDone <= 1'b0;
      evictWb   <= 1'b0;
      if (opSel == OP_EVICT) begin
        if (rdRec.inL1) begin
          fsm      <= FSM_CMD;
          subCnt   <= '0;
          evIdxQ   <= opIdx;
          evFlushQ <= rdRec.dirtyL1;
          evWbQ    <= (rdRec.st == LINE_M);
        end else begin
          evictDone <= 1'b1;
          evictWb   <= (rdRec.st == LINE_M);
        end
      end else if (busy && l1Ack) begin
        if (lastAck) begin
          fsm       <= FSM_IDLE;
          evictDone <= 1'b1;
          evictWb   <= evWbQ;
        end else begin
          subCnt <= subCnt + SUB_W'(1);
        end
      end
    end
  end

  assign l1CmdValid = busy;
  assign l1CmdOp    = evFlushQ;
  assign l1CmdSub   = subCnt;
  assign l1CmdIdx   = evIdxQ;

endmodule

// File: rtl/incl_filter.sv
module incl_filter
  import incl_filter_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int SUB_COUNT = 2,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SUB_W = (SUB_COUNT > 1) ? $clog2(SUB_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             snoopValid,
  input  logic             snoopExcl,
  input  logic [IDX_W-1:0] snoopIdx,
  input  logic             fillValid,
  input  logic             fillWrite,
  input  logic             fillShared,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictIdx,
  input  logic             l1WbValid,
  input  logic [IDX_W-1:0] l1WbIdx,
  input  logic             l1EvictValid,
  input  logic [IDX_W-1:0] l1EvictIdx,
  input  logic             l1Ack,
  input  logic [IDX_W-1:0] qIdx,
  output logic             busy,
  output logic             snoopHit,
  output logic             snoopDirty,
  output logic             fwdValid,
  output logic             fwdExcl,
  output logic             fwdFlush,
  output logic [IDX_W-1:0] fwdIdx,
  output logic             l1CmdValid,
  output logic             l1CmdOp,
  output logic [SUB_W-1:0] l1CmdSub,
  output logic [IDX_W-1:0] l1CmdIdx,
  output logic             evictDone,
  output logic             evictWb,
  output logic [1:0]       qState,
  output logic             qInL1,
  output logic             qDirtyL1
);

  tblStrobe_t       strobe;
  lineRec_t         rdRec;
  lineRec_t         qRec;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;

  incl_line_table #(.NUM_LINES(NUM_LINES)) table_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrIdx (wrIdx),
    .rdIdx (rdIdx),
    .rdRec (rdRec),
    .qIdx  (qIdx),
    .qRec  (qRec)
  );

  incl_ctrl #(.NUM_LINES(NUM_LINES), .SUB_COUNT(SUB_COUNT)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .snoopValid  (snoopValid),
    .snoopExcl   (snoopExcl),
    .snoopIdx    (snoopIdx),
    .fillValid   (fillValid),
    .fillWrite   (fillWrite),
    .fillShared  (fillShared),
    .fillIdx     (fillIdx),
    .evictValid  (evictValid),
    .evictIdx    (evictIdx),
    .l1WbValid   (l1WbValid),
    .l1WbIdx     (l1WbIdx),
    .l1EvictValid(l1EvictValid),
    .l1EvictIdx  (l1EvictIdx),
    .l1Ack       (l1Ack),
    .rdRec       (rdRec),
    .rdIdx       (rdIdx),
    .wrIdx       (wrIdx),
    .strobe      (strobe),
    .busy        (busy),
    .snoopHit    (snoopHit),
    .snoopDirty  (snoopDirty),
    .fwdValid    (fwdValid),
    .fwdExcl     (fwdExcl),
    .fwdFlush    (fwdFlush),
    .fwdIdx      (fwdIdx),
    .l1CmdValid  (l1CmdValid),
    .l1CmdOp     (l1CmdOp),
    .l1CmdSub    (l1CmdSub),
    .l1CmdIdx    (l1CmdIdx),
    .evictDone   (evictDone),
    .evictWb     (evictWb)
  );

  assign qState   = qRec.st;
  assign qInL1    = qRec.inL1;
  assign qDirtyL1 = qRec.dirtyL1;

endmodule

// File: rtl/incl_filter_checker.sv
module incl_filter_checker #(
  parameter int NUM_LINES = 8,
  parameter int SUB_COUNT = 2,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SUB_W = (SUB_COUNT > 1) ? $clog2(SUB_COUNT) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             snoopValid,
  input logic             l1Ack,
  input logic             snoopHit,
  input logic             snoopDirty,
  input logic             fwdValid,
  input logic             fwdFlush,
  input logic             l1CmdValid,
  input logic             l1CmdOp,
  input logic [SUB_W-1:0] l1CmdSub,
  input logic [IDX_W-1:0] l1CmdIdx,
  input logic             evictDone,
  input logic [1:0]       qState,
  input logic             qInL1,
  input logic             qDirtyL1
);

  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUB_COUNT - 1);

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (l1CmdValid && !l1Ack) |=> (l1CmdValid && $stable(l1CmdSub) &&
                                $stable(l1CmdIdx) && $stable(l1CmdOp)));

  assert_sub_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (l1CmdValid && l1Ack && (l1CmdSub != LAST_SUB)) |=>
      (l1CmdValid && (l1CmdSub == $past(l1CmdSub) + SUB_W'(1))));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (l1CmdValid && l1Ack && (l1CmdSub == LAST_SUB)) |=> (evictDone && !l1CmdValid));

  assert_fwd_from_snoop_R5: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> ($past(snoopValid) && snoopHit));

  assert_flush_is_modified_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdFlush) |-> snoopDirty);

  assert_dirty_inclusion_R13: assert property (@(posedge clk) disable iff (!rstN)
    qDirtyL1 |-> (qInL1 && (qState == 2'd3)));

  assert_presence_inclusion_R13: assert property (@(posedge clk) disable iff (!rstN)
    qInL1 |-> (qState != 2'd0));

endmodule

bind incl_filter incl_filter_checker #(.NUM_LINES(NUM_LINES), .SUB_COUNT(SUB_COUNT)) chk_i (.*);

// File: tb/incl_filter_tb.sv
module incl_filter_tb_top;

  localparam int NL = 8;
  localparam int SC = 2;
  localparam int IW = 3;
  localparam int SW = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snoopValid = 0, snoopExcl = 0;
  logic [IW-1:0] snoopIdx = '0;
  logic fillValid = 0, fillWrite = 0, fillShared = 0;
  logic [IW-1:0] fillIdx = '0;
  logic evictValid = 0;
  logic [IW-1:0] evictIdx = '0;
  logic l1WbValid = 0;
  logic [IW-1:0] l1WbIdx = '0;
  logic l1EvictValid = 0;
  logic [IW-1:0] l1EvictIdx = '0;
  logic l1Ack = 0;
  logic [IW-1:0] qIdx = '0;
  logic busy, snoopHit, snoopDirty, fwdValid, fwdExcl, fwdFlush;
  logic [IW-1:0] fwdIdx, l1CmdIdx;
  logic l1CmdValid, l1CmdOp, evictDone, evictWb;
  logic [SW-1:0] l1CmdSub;
  logic [1:0] qState;
  logic qInL1, qDirtyL1;

  int nChecks = 0;
  int nFails = 0;

  int mSt [NL];
  bit mIn [NL];
  bit mDirty [NL];

  always #10 clk = ~clk;

  incl_filter #(.NUM_LINES(NL), .SUB_COUNT(SC)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic checkLine(input string req, input int idx);
    qIdx = IW'(idx);
    #1;
    chk(req, int'(qState), mSt[idx]);
    chk(req, int'(qInL1), int'(mIn[idx]));
    chk(req, int'(qDirtyL1), int'(mDirty[idx]));
  endtask

  task automatic doFill(input int idx, input bit wr, input bit sh);
    fillValid = 1; fillIdx = IW'(idx); fillWrite = wr; fillShared = sh;
    @(negedge clk);
    fillValid = 0;
    mSt[idx] = wr ? 3 : (sh ? 1 : 2);
    mIn[idx] = 1;
    mDirty[idx] = wr;
  endtask

  task automatic doSnoop(input int idx, input bit ex);
    snoopValid = 1; snoopIdx = IW'(idx); snoopExcl = ex;
    @(negedge clk);
    snoopValid = 0;
    chk("R4 hit", int'(snoopHit), int'(mSt[idx] != 0));
    chk("R4 dirty", int'(snoopDirty), int'(mSt[idx] == 3));
    chk("R5 fwd", int'(fwdValid), int'(mIn[idx]));
    chk("R5 flush", int'(fwdFlush), int'(mIn[idx] && mDirty[idx]));
    if (mIn[idx]) begin
      chk("R5 idx", int'(fwdIdx), idx);
      chk("R5 excl", int'(fwdExcl), int'(ex));
    end
    if (ex) begin
      mSt[idx] = 0; mIn[idx] = 0; mDirty[idx] = 0;
    end else begin
      if (mSt[idx] != 0) mSt[idx] = 1;
      mDirty[idx] = 0;
    end
    checkLine("R6 snoop state", idx);
  endtask

  task automatic doEvict(input int idx, input bit poke);
    int nb;
    nb = (idx + 1) % NL;
    evictValid = 1; evictIdx = IW'(idx);
    @(negedge clk);
    evictValid = 0;
    if (mIn[idx]) begin
      for (int s = 0; s < SC; s++) begin
        int d;
        d = (idx + s) % 3;
        chk("R7 valid", int'(l1CmdValid), 1);
        chk("R7 sub", int'(l1CmdSub), s);
        chk("R7 op", int'(l1CmdOp), int'(mDirty[idx]));
        chk("R7 idx", int'(l1CmdIdx), idx);
        chk("R11 busy", int'(busy), 1);
        for (int w = 0; w < d; w++) begin
          if (poke && s == 0 && w == 0) begin
            fillValid = 1; fillIdx = IW'(nb); fillWrite = 1;
          end
          @(negedge clk);
          fillValid = 0;
          chk("R7 hold", int'(l1CmdValid), 1);
          chk("R7 hold sub", int'(l1CmdSub), s);
        end
        l1Ack = 1;
        @(negedge clk);
        l1Ack = 0;
      end
    end else begin
      chk("R8 no cmd", int'(l1CmdValid), 0);
    end
    chk("R8 done", int'(evictDone), 1);
    chk("R8 wb", int'(evictWb), int'(mSt[idx] == 3));
    chk("R8 idle", int'(busy), 0);
    mSt[idx] = 0; mIn[idx] = 0; mDirty[idx] = 0;
    checkLine("R8 line cleared", idx);
    @(negedge clk);
    chk("R8 pulse", int'(evictDone), 0);
    if (poke) checkLine("R11 ignored fill", nb);
  endtask

  task automatic doWb(input int idx);
    l1WbValid = 1; l1WbIdx = IW'(idx);
    @(negedge clk);
    l1WbValid = 0;
    mDirty[idx] = 0;
    checkLine("R10 write-back", idx);
  endtask

  task automatic doL1Ev(input int idx);
    l1EvictValid = 1; l1EvictIdx = IW'(idx);
    @(negedge clk);
    l1EvictValid = 0;
    mIn[idx] = 0; mDirty[idx] = 0;
    checkLine("R9 L1 drop", idx);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mSt[i] = 0; mIn[i] = 0; mDirty[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 fwd", int'(fwdValid), 0);
    chk("R1 hit", int'(snoopHit), 0);
    chk("R1 dirty", int'(snoopDirty), 0);
    chk("R1 cmd", int'(l1CmdValid), 0);
    chk("R1 done", int'(evictDone), 0);
    for (int i = 0; i < NL; i++) checkLine("R1 reset line", i);

    // Sweep: every line, every preparation, every operation.
    for (int idx = 0; idx < NL; idx++) begin
      for (int p = 0; p < 6; p++) begin
        for (int op = 0; op < 5; op++) begin
          case (p)
            1: begin doFill(idx, 0, 1); checkLine("R2 read shared", idx); end
            2: begin doFill(idx, 0, 0); checkLine("R2 read excl", idx); end
            3: begin doFill(idx, 1, 0); checkLine("R3 write fill", idx); end
            4: begin doFill(idx, 1, 0); doWb(idx); end
            5: begin doFill(idx, 0, 0); doL1Ev(idx); end
            default: ;
          endcase
          case (op)
            0: doSnoop(idx, 0);
            1: doSnoop(idx, 1);
            2: doEvict(idx, (p == 3));
            3: if (mSt[idx] == 3 && mDirty[idx]) doWb(idx); else doL1Ev(idx);
            default: doL1Ev(idx);
          endcase
          doEvict(idx, 0);
        end
      end
    end

    // R12: snoop beats a same-cycle fill to another line.
    doFill(2, 1, 0);
    snoopValid = 1; snoopIdx = 3'd2; snoopExcl = 1;
    fillValid = 1; fillIdx = 3'd5; fillWrite = 1;
    @(negedge clk);
    snoopValid = 0; fillValid = 0;
    chk("R12 snoop taken", int'(fwdValid), 1);
    mSt[2] = 0; mIn[2] = 0; mDirty[2] = 0;
    checkLine("R12 snoop applied", 2);
    checkLine("R12 fill dropped", 5);

    // R12: eviction beats fill and L1 write-back.
    doFill(4, 0, 0);
    evictValid = 1; evictIdx = 3'd6;
    fillValid = 1; fillIdx = 3'd4; fillWrite = 1;
    l1WbValid = 1; l1WbIdx = 3'd4;
    @(negedge clk);
    evictValid = 0; fillValid = 0; l1WbValid = 0;
    chk("R12 evict taken", int'(evictDone), 1);
    checkLine("R12 fill lost to evict", 4);

    // R12: fill beats L1 eviction notice.
    fillValid = 1; fillIdx = 3'd1; fillWrite = 0; fillShared = 1;
    l1EvictValid = 1; l1EvictIdx = 3'd4;
    @(negedge clk);
    fillValid = 0; l1EvictValid = 0;
    mSt[1] = 1; mIn[1] = 1; mDirty[1] = 0;
    checkLine("R12 fill applied", 1);
    checkLine("R12 notice dropped", 4);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule